// File: doc/BRIEF.md
# Interrupt Source Mask and Route Block

This block gathers a vector of level-sensitive hardware interrupt lines and a set of software-raisable interrupt bits into a single pending vector. Each source can be enabled for the normal interrupt path, and each source can be steered to a fast interrupt path. The normal path produces a per-source request vector for a separate priority resolver. The fast path collapses to one output line, and that line does not look at the enable mask.

Software reaches the block over a simple word-addressed register bus. Each access lasts one cycle and is marked by a write strobe or a read strobe. Read data appears in a register one cycle after the read strobe is sampled. The enable bits and the software interrupt bits are never written directly: each has one word that sets bits and another word that clears bits. A one-bit protection flag is kept so software can read it back, but nothing acts on it. The hardware lines pass through a synchronizer before they reach any status.

Top module: `intsrc_router`

## Requirements
- R1: The raw pending vector is the OR of the synchronized hardware lines and the software interrupt register. It is read at word 2 (byte 0x08).
- R2: The normal status is raw AND enable AND NOT route. It is read at word 0 (byte 0x00), and the `normalReq` port always shows the same value.
- R3: The fast status is raw AND route, with no enable term. It is read at word 1 (byte 0x04), and `fastIrq` is high exactly when the fast status is nonzero.
- R4: The route register, where a bit set to 1 steers that source to the fast path, is written and read at word 3 (byte 0x0C).
- R5: A write to word 4 (0x10) ORs the data into the enable register. A write to word 5 (0x14) clears every enable bit written as 1. A read of word 4 returns the enable register.
- R6: A write to word 6 (0x18) ORs the data into the software interrupt register. A write to word 7 (0x1C) clears every bit written as 1. A read of word 6 returns the software interrupt register.
- R7: Word 8 (0x20) holds a protection flag taken from data bit 0. A read returns the flag in bit 0 and zeros in all other bits.
- R8: Writes to word 0 (status) and to words 1 and 2 change no register.
- R9: Reads of undefined words return zero, and so do reads of the clear-only words 5 and 7. Writes to undefined words change no register.
- R10: After reset, every register, `busRdData`, `normalReq` and `fastIrq` are zero.
- R11: A change on `hwIrq` reaches the status outputs after exactly SYNC_STAGES rising clock edges. With the default of 2, the change is not yet visible after one edge.
- R12: `busRdData` shows the selected word one cycle after the read strobe is sampled, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; all registers clear to zero |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | ADDR_W | Word index of the register |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Registered read data |
| hwIrq | input | NUM_SRC | Asynchronous level-sensitive hardware interrupt lines |
| normalReq | output | NUM_SRC | Normal-path request vector for the priority resolver |
| fastIrq | output | 1 | Fast interrupt output |

## Verification
The bench builds the block with its default parameters: 32 sources, a 32-bit data bus, a 10-bit word index and a two-stage synchronizer. With 32 sources, both the top source (bit 31) and the bottom source (bit 0) can be driven and read back at full width. With two synchronizer stages, the bench can observe the point one edge after a line changes, when the change must not yet show, and the point after the second edge, when it must. A 10-bit word index lets the bench read and write the highest word as well as the unused words just above the defined map.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

  // Word indices on the register bus
  localparam int unsigned IDX_NORM_STAT = 0;
  localparam int unsigned IDX_FAST_STAT = 1;
  localparam int unsigned IDX_RAW       = 2;
  localparam int unsigned IDX_ROUTE     = 3;
  localparam int unsigned IDX_EN_SET    = 4;
  localparam int unsigned IDX_EN_CLR    = 5;
  localparam int unsigned IDX_SOFT_SET  = 6;
  localparam int unsigned IDX_SOFT_CLR  = 7;
  localparam int unsigned IDX_PROT      = 8;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_NORM,
    SRC_FAST,
    SRC_RAW,
    SRC_ROUTE,
    SRC_EN,
    SRC_SOFT,
    SRC_PROT
  } rdSrc_e;

  typedef struct packed {
    logic   routeWr;
    logic   enSet;
    logic   enClr;
    logic   softSet;
    logic   softClr;
    logic   protWr;
    logic   rdLoad;
    rdSrc_e rdSrc;
  } regStrobe_t;

endpackage

// File: rtl/intsrc_sync.sv
module intsrc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl
  import intsrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] A_NORM  = ADDR_W'(IDX_NORM_STAT);
  localparam logic [ADDR_W-1:0] A_FAST  = ADDR_W'(IDX_FAST_STAT);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(IDX_RAW);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(IDX_ROUTE);
  localparam logic [ADDR_W-1:0] A_ENS   = ADDR_W'(IDX_EN_SET);
  localparam logic [ADDR_W-1:0] A_ENC   = ADDR_W'(IDX_EN_CLR);
  localparam logic [ADDR_W-1:0] A_SFS   = ADDR_W'(IDX_SOFT_SET);
  localparam logic [ADDR_W-1:0] A_SFC   = ADDR_W'(IDX_SOFT_CLR);
  localparam logic [ADDR_W-1:0] A_PROT  = ADDR_W'(IDX_PROT);

  rdSrc_e readSel;

  // Read source decode; clear-only and undefined words read as zero
  always_comb begin
    if      (busAddr == A_NORM)  readSel = SRC_NORM;
    else if (busAddr == A_FAST)  readSel = SRC_FAST;
    else if (busAddr == A_RAW)   readSel = SRC_RAW;
    else if (busAddr == A_ROUTE) readSel = SRC_ROUTE;
    else if (busAddr == A_ENS)   readSel = SRC_EN;
    else if (busAddr == A_SFS)   readSel = SRC_SOFT;
    else if (busAddr == A_PROT)  readSel = SRC_PROT;
    else                         readSel = SRC_ZERO;
  end

  // Write strobe decode; status words and undefined words get no strobe
  always_comb begin
    strb         = '0;
    strb.rdLoad  = busRdEn;
    strb.rdSrc   = readSel;
    if (busWrEn) begin
      strb.routeWr = (busAddr == A_ROUTE);
      strb.enSet   = (busAddr == A_ENS);
      strb.enClr   = (busAddr == A_ENC);
      strb.softSet = (busAddr == A_SFS);
      strb.softClr = (busAddr == A_SFC);
      strb.protWr  = (busAddr == A_PROT);
    end
  end

endmodule

// File: rtl/intsrc_datapath.sv
module intsrc_datapath
  import intsrc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] hwSync,
  output logic [NUM_SRC-1:0] rawVec,
  output logic [NUM_SRC-1:0] enableVec,
  output logic [NUM_SRC-1:0] routeVec,
  output logic [NUM_SRC-1:0] softVec,
  output logic [NUM_SRC-1:0] normalReq,
  output logic               fastIrq,
  output logic [DATA_W-1:0]  rdData
);

  logic [NUM_SRC-1:0] srcData;
  logic [NUM_SRC-1:0] fastVec;
  logic               protQ;
  logic [DATA_W-1:0]  rdNext;

  assign srcData = wrData[NUM_SRC-1:0];

  // Route select register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             routeVec <= '0;
    else if (strb.routeWr) routeVec <= srcData;
  end

  // Enable register: set-only and clear-only access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           enableVec <= '0;
    else if (strb.enSet) enableVec <= enableVec | srcData;
    else if (strb.enClr) enableVec <= enableVec & ~srcData;
  end

  // Software interrupt register: set-only and clear-only access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             softVec <= '0;
    else if (strb.softSet) softVec <= softVec | srcData;
    else if (strb.softClr) softVec <= softVec & ~srcData;
  end

  // Stored protection flag, never enforced
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            protQ <= 1'b0;
    else if (strb.protWr) protQ <= wrData[0];
  end

  // Pending and routed status
  assign rawVec    = hwSync | softVec;
  assign normalReq = rawVec & enableVec & ~routeVec;
  assign fastVec   = rawVec & routeVec;
  assign fastIrq   = |fastVec;

  always_comb begin
    unique case (strb.rdSrc)
      SRC_NORM:  rdNext = DATA_W'(normalReq);
      SRC_FAST:  rdNext = DATA_W'(fastVec);
      SRC_RAW:   rdNext = DATA_W'(rawVec);
      SRC_ROUTE: rdNext = DATA_W'(routeVec);
      SRC_EN:    rdNext = DATA_W'(enableVec);
      SRC_SOFT:  rdNext = DATA_W'(softVec);
      SRC_PROT:  rdNext = DATA_W'(protQ);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= rdNext;
  end

endmodule

// File: rtl/intsrc_router.sv
module intsrc_router
  import intsrc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] hwIrq,
  output logic [NUM_SRC-1:0] normalReq,
  output logic               fastIrq
);

  regStrobe_t         strb;
  logic [NUM_SRC-1:0] hwSync;
  logic [NUM_SRC-1:0] rawVec;
  logic [NUM_SRC-1:0] enableVec;
  logic [NUM_SRC-1:0] routeVec;
  logic [NUM_SRC-1:0] softVec;

  intsrc_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (hwIrq),
    .syncOut (hwSync)
  );

  intsrc_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  intsrc_datapath #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .hwSync    (hwSync),
    .rawVec    (rawVec),
    .enableVec (enableVec),
    .routeVec  (routeVec),
    .softVec   (softVec),
    .normalReq (normalReq),
    .fastIrq   (fastIrq),
    .rdData    (busRdData)
  );

endmodule

// File: rtl/intsrc_router_chk.sv
module intsrc_router_chk
  import intsrc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic [NUM_SRC-1:0] enableVec,
  input logic [NUM_SRC-1:0] routeVec,
  input logic [NUM_SRC-1:0] softVec,
  input logic [NUM_SRC-1:0] normalReq,
  input logic               fastIrq
);

  localparam logic [ADDR_W-1:0] A_NORM = ADDR_W'(IDX_NORM_STAT);
  localparam logic [ADDR_W-1:0] A_ENS  = ADDR_W'(IDX_EN_SET);
  localparam logic [ADDR_W-1:0] A_ENC  = ADDR_W'(IDX_EN_CLR);
  localparam logic [ADDR_W-1:0] A_SFS  = ADDR_W'(IDX_SOFT_SET);
  localparam logic [ADDR_W-1:0] A_SFC  = ADDR_W'(IDX_SOFT_CLR);

  // R5
  enable_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_ENS) |=>
      ((enableVec & $past(busWrData[NUM_SRC-1:0])) == $past(busWrData[NUM_SRC-1:0])));

  // R5
  enable_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_ENC) |=>
      ((enableVec & $past(busWrData[NUM_SRC-1:0])) == '0));

  // R6
  soft_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_SFS) |=>
      ((softVec & $past(busWrData[NUM_SRC-1:0])) == $past(busWrData[NUM_SRC-1:0])));

  // R6
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_SFC) |=>
      ((softVec & $past(busWrData[NUM_SRC-1:0])) == '0));

  // R8
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_NORM) |=>
      ($stable(enableVec) && $stable(routeVec) && $stable(softVec)));

  // R2
  normal_excludes_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normalReq & routeVec) == '0);

  // R2
  normal_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normalReq & ~enableVec) == '0);

  // R3
  fast_needs_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (routeVec == '0) |-> !fastIrq);

endmodule

bind intsrc_router intsrc_router_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .enableVec (enableVec),
  .routeVec  (routeVec),
  .softVec   (softVec),
  .normalReq (normalReq),
  .fastIrq   (fastIrq)
);

// File: tb/intsrc_router_tb.sv
module intsrc_router_tb;

  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned WATCHDOG_CYC = 20000;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busWrEn = 1'b0;
  logic               busRdEn = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic [DATA_W-1:0]  busWrData = '0;
  logic [DATA_W-1:0]  busRdData;
  logic [NUM_SRC-1:0] hwIrq = '0;
  logic [NUM_SRC-1:0] normalReq;
  logic               fastIrq;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];
  logic              rdIssued = 1'b0;

  // Bench-side model state
  logic [NUM_SRC-1:0] hwM = '0, softM = '0, enM = '0, selM = '0;

  always #4 clk = ~clk;  // 125 MHz

  intsrc_router u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .hwIrq     (hwIrq),
    .normalReq (normalReq),
    .fastIrq   (fastIrq)
  );

  function automatic logic [NUM_SRC-1:0] mRaw();
    return hwM | softM;
  endfunction
  function automatic logic [NUM_SRC-1:0] mNorm();
    return mRaw() & enM & ~selM;
  endfunction
  function automatic logic [NUM_SRC-1:0] mFast();
    return mRaw() & selM;
  endfunction

  // Monitor: compare read data one cycle after the strobe was sampled
  always @(posedge clk) rdIssued <= busRdEn;

  always @(negedge clk) begin
    if (rdIssued && expQ.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkCnt++;
      if (busRdData !== e) begin
        failCnt++;
        $display("FAIL %s: read got %h expected %h", t, busRdData, e);
      end
    end
  end

  task automatic busWrite(input int idx, input logic [DATA_W-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = ADDR_W'(idx); busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input int idx, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = ADDR_W'(idx);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic checkPorts(input string t);
    checkCnt++;
    if (normalReq !== mNorm() || fastIrq !== (|mFast())) begin
      failCnt++;
      $display("FAIL %s: normalReq=%h fastIrq=%b expected %h %b",
               t, normalReq, fastIrq, mNorm(), |mFast());
    end
  endtask

  task automatic readAllState(input string t);
    busRead(0, DATA_W'(mNorm()), {t, " norm"});
    busRead(1, DATA_W'(mFast()), {t, " fast"});
    busRead(2, DATA_W'(mRaw()),  {t, " raw"});
    busRead(3, DATA_W'(selM),    {t, " route"});
    busRead(4, DATA_W'(enM),     {t, " enable"});
    busRead(6, DATA_W'(softM),   {t, " soft"});
  endtask

  task automatic drainQ();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state at the ports and in every register
    checkCnt++;
    if (busRdData !== '0) begin
      failCnt++;
      $display("FAIL R10: busRdData=%h expected %h", busRdData, {DATA_W{1'b0}});
    end
    checkPorts("R10 ports");
    readAllState("R10");
    busRead(8, '0, "R10 prot");

    // R6 / R1: software set and raw pending
    busWrite(6, 32'h0000_00F0); softM = 32'h0000_00F0;
    busRead(6, 32'h0000_00F0, "R6 soft set");
    busRead(2, 32'h0000_00F0, "R1 raw from soft");

    // R5: enable set ORs in
    busWrite(4, 32'h0000_0030); enM = 32'h30;
    busWrite(4, 32'h0000_0001); enM = 32'h31;
    busRead(4, 32'h0000_0031, "R5 enable or");
    busRead(0, 32'h0000_0030, "R2 normal status");
    checkPorts("R2 normalReq");

    // R4 / R3: route bit 5 to fast path
    busWrite(3, 32'h0000_0020); selM = 32'h20;
    busRead(3, 32'h0000_0020, "R4 route readback");
    busRead(0, 32'h0000_0010, "R2 routed bit removed");
    busRead(1, 32'h0000_0020, "R3 fast status");
    checkPorts("R3 fastIrq high");

    // R3 / R5: clearing enable does not affect the fast path
    busWrite(5, 32'h0000_0020); enM = 32'h11;
    busRead(4, 32'h0000_0011, "R5 enable clear");
    busRead(1, 32'h0000_0020, "R3 fast ignores enable");
    checkPorts("R3 fastIrq ignores enable");

    // R11: hardware line latency through synchronizer
    busWrite(4, 32'h8000_0000); enM = 32'h8000_0011;
    drainQ();
    @(negedge clk);
    hwIrq = 32'h8000_0001;
    @(negedge clk);
    checkCnt++;
    if (normalReq !== 32'h0000_0010) begin
      failCnt++;
      $display("FAIL R11: after one edge normalReq=%h expected %h", normalReq, 32'h10);
    end
    @(negedge clk);
    hwM = 32'h8000_0001;
    checkPorts("R11 after two edges");
    readAllState("R1 hw plus soft");

    // R6: soft clear
    busWrite(7, 32'h0000_00F0); softM = '0;
    busRead(6, '0, "R6 soft clear");
    busRead(2, 32'h8000_0001, "R1 raw hw only");
    checkPorts("R6 ports after clear");

    // R8: writes to status words change nothing
    busWrite(0, '1);
    busWrite(1, '1);
    busWrite(2, '1);
    readAllState("R8");
    checkPorts("R8 ports");

    // R9: undefined words read zero and writes to them are ignored
    busWrite(9, '1);
    busWrite(10'h3FF, '1);
    busRead(5, '0, "R9 clear word reads zero");
    busRead(7, '0, "R9 soft clear word reads zero");
    busRead(9, '0, "R9 undefined word");
    busRead(10'h3FF, '0, "R9 top word");
    readAllState("R9 state kept");

    // R7: protection flag bit 0 only
    busWrite(8, 32'hFFFF_FFFE);
    busRead(8, '0, "R7 prot bit0 clear");
    busWrite(8, 32'h0000_0003);
    busRead(8, 32'h0000_0001, "R7 prot bit0 set");

    // R12: read data holds between reads
    drainQ();
    busWrite(4, 32'h0000_0100); enM = 32'h8000_0111;
    repeat (2) @(negedge clk);
    checkCnt++;
    if (busRdData !== 32'h0000_0001) begin
      failCnt++;
      $display("FAIL R12: held read data %h expected %h", busRdData, 32'h1);
    end

    // R3: fast output drops when routed sources go idle
    busWrite(3, 32'h8000_0000); selM = 32'h8000_0000;
    checkPorts("R3 route top bit");
    @(negedge clk);
    hwIrq = '0;
    repeat (2) @(negedge clk);
    hwM = '0;
    checkPorts("R3 fastIrq low");
    readAllState("R1 idle");

    drainQ();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run stalled, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule